// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Software Fill

This block is a small fully associative translation buffer whose contents are managed by software. Each slot holds a virtual page tag, an address-space identifier, a per-slot size mask, a global flag and two physical frame halves (even and odd). Each half has its own frame number, a 3-bit cache attribute, a dirty flag and a valid flag. A lookup presents a full virtual address and an address-space identifier. One cycle later the block returns hit or miss, the winning slot index (or all ones on a miss), and the frame and attributes of the selected half. It also flags a half that exists but is not valid, and flags addresses in the fixed uncached window.

Software fills a slot by writing it at an explicit index. It can read any slot back in the same packed word format. A replacement pointer names the next slot to use. A read through that pointer may step it forward, and the step wraps at the last slot. A flush command empties the whole table and returns the pointer to zero.

The virtual address splits into a page offset of `PAGE_SHIFT` bits, one half-select bit and a page tag of `VA_W-PAGE_SHIFT-1` bits. Mask bit k removes tag bit k from the compare.

Top module: `tlb_paired_xlate`

## Requirements
- R1: A slot matches a lookup when the lookup tag (`lk_vaddr[VA_W-1:PAGE_SHIFT+1]`) equals the stored tag in every bit where the slot's mask bit is 0. Bits where the mask is 1 are ignored.
- R2: The identifier condition passes when the slot's global flag is set or when `lk_asid` equals the stored identifier. The global flag is the AND of bit 0 of the two frame words written.
- R3: A slot takes part in lookups only when at least one of its two valid bits (frame word bit 1) is set.
- R4: The half is chosen by bit `c` of `{tag, lk_vaddr[PAGE_SHIFT]}`, where c is the number of set mask bits (masks are contiguous from bit 0). 0 selects the even half and 1 selects the odd half. On a hit, `res_pfn`, `res_cattr` and `res_dirty` come from that half, and `res_inval` is 1 when that half's valid bit is 0. On a miss these outputs are all 0.
- R5: `res_probe` gives the winning slot index on a hit and all ones on a miss.
- R6: When several slots match, the lowest index wins.
- R7: A write replaces the whole slot at `wr_idx`. A write with `wr_idx >= ENTRIES` changes nothing.
- R8: A read returns the slot one cycle later. `rd_tag` is `{tag, asid}` and `rd_mask` is the mask. Each frame word is `{pfn, cattr[2:0], dirty, valid, global}` from bit 0 upward: global at bit 0, valid at bit 1, dirty at bit 2, cattr at bits 5:3, pfn above. A read with an index of `ENTRIES` or more returns zeros.
- R9: `flush` clears every field of every slot and sets `nlu_ptr` to 0. It takes priority over a write in the same cycle.
- R10: A read with `rd_use_nlu` set reads the slot at `nlu_ptr`. When `rd_advance` is also set, the pointer steps by one afterwards and wraps from `ENTRIES-1` to 0. Any other read leaves the pointer unchanged.
- R11: `res_uncached` is 1 exactly when both `lk_vaddr[31]` and `lk_vaddr[29]` are set, whatever the table holds.
- R12: Lookup results appear on the outputs at the first clock edge after the inputs. After reset the table is empty, `res_hit` is 0, `res_probe` is all ones and `nlu_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| wr_en | input | 1 | Write a slot |
| wr_idx | input | IDX_W+1 | Slot index for the write |
| wr_tag | input | VPN_W+ASID_W | Packed {tag, asid} |
| wr_mask | input | VPN_W | Size mask |
| wr_even | input | PFN_W+6 | Even frame word |
| wr_odd | input | PFN_W+6 | Odd frame word |
| rd_en | input | 1 | Read a slot |
| rd_idx | input | IDX_W+1 | Slot index for the read |
| rd_use_nlu | input | 1 | Read at the replacement pointer |
| rd_advance | input | 1 | Step the pointer after a pointer read |
| flush | input | 1 | Clear the table and the pointer |
| res_hit | output | 1 | Lookup hit |
| res_probe | output | IDX_W+1 | Winning index, all ones on a miss |
| res_pfn | output | PFN_W | Frame of the selected half |
| res_cattr | output | 3 | Cache attribute of the selected half |
| res_dirty | output | 1 | Dirty flag of the selected half |
| res_inval | output | 1 | Hit on a half that is not valid |
| res_uncached | output | 1 | Address lies in the uncached window |
| rd_tag | output | VPN_W+ASID_W | Read-back {tag, asid} |
| rd_mask | output | VPN_W | Read-back mask |
| rd_even | output | PFN_W+6 | Read-back even frame word |
| rd_odd | output | PFN_W+6 | Read-back odd frame word |
| nlu_ptr | output | IDX_W | Replacement pointer |

## Verification
A corrupted slot shows up on the next lookup whose address lands in that slot's masked range. It appears as a wrong frame, a wrong probe index, or a false hit or miss, one clock after the address is presented. A full read-back of the table also exposes it. A bad priority choice or a wrong half selection shows only when overlapping slots or both address halves are swept. The bench therefore crosses every configured slot with offsets around its tag, several identifiers and both half bits. A pointer fault shows on the next pointer read, both as the returned slot and on `nlu_ptr`.

// File: rtl/tlb_pkg.sv
// Shared field positions of the packed frame word used at the write and
// read ports and inside the table. Assumes the frame word is PFN_W+6 wide.
package tlb_pkg;
    localparam int FB_GLOBAL = 0;
    localparam int FB_VALID  = 1;
    localparam int FB_DIRTY  = 2;
    localparam int FB_CA_LO  = 3;
    localparam int CA_W      = 3;
    localparam int META_W    = 6;

    typedef logic [CA_W-1:0] cattr_t;
endpackage

// File: rtl/tlb_entry_store.sv
// Slot storage, indexed write and read, flush, and the replacement pointer.
// Assumes ENTRIES >= 2. Writes and reads at an index of ENTRIES or more are
// dropped (write) or return zeros (read). Flush wins over a same-cycle write.
module tlb_entry_store #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PIDX_W = IDX_W + 1,
    localparam int TAG_W  = VPN_W + ASID_W,
    localparam int FRM_W  = PFN_W + tlb_pkg::META_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic                             wr_en,
    input  logic [PIDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic [VPN_W-1:0]                 wr_mask,
    input  logic [FRM_W-1:0]                 wr_even,
    input  logic [FRM_W-1:0]                 wr_odd,
    input  logic                             rd_en,
    input  logic [PIDX_W-1:0]                rd_idx,
    input  logic                             rd_use_nlu,
    input  logic                             rd_advance,
    output logic [ENTRIES-1:0][TAG_W-1:0]    tag_q,
    output logic [ENTRIES-1:0][VPN_W-1:0]    mask_q,
    output logic [ENTRIES-1:0][FRM_W-1:0]    even_q,
    output logic [ENTRIES-1:0][FRM_W-1:0]    odd_q,
    output logic [ENTRIES-1:0]               occ,
    output logic [TAG_W-1:0]                 rd_tag,
    output logic [VPN_W-1:0]                 rd_mask,
    output logic [FRM_W-1:0]                 rd_even,
    output logic [FRM_W-1:0]                 rd_odd,
    output logic [IDX_W-1:0]                 nlu_ptr
);
    import tlb_pkg::*;

    logic              wr_in_range;
    logic              wr_glob;
    logic [PIDX_W-1:0] rd_addr;
    logic              rd_in_range;
    logic              nlu_step;

    // Decode write range, combined global flag and the read address.
    always_comb begin
        wr_in_range = (int'(wr_idx) < ENTRIES);
        wr_glob     = wr_even[FB_GLOBAL] & wr_odd[FB_GLOBAL];
        rd_addr     = rd_use_nlu ? {1'b0, nlu_ptr} : rd_idx;
        rd_in_range = (int'(rd_addr) < ENTRIES);
        nlu_step    = rd_en & rd_use_nlu & rd_advance;
    end

    // Slot array: cleared on reset or flush, otherwise written whole.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                mask_q[i] <= '0;
                even_q[i] <= '0;
                odd_q[i]  <= '0;
            end
        end else if (wr_en && wr_in_range) begin
            tag_q[wr_idx[IDX_W-1:0]]  <= wr_tag;
            mask_q[wr_idx[IDX_W-1:0]] <= wr_mask;
            even_q[wr_idx[IDX_W-1:0]] <= {wr_even[FRM_W-1:1], wr_glob};
            odd_q[wr_idx[IDX_W-1:0]]  <= {wr_odd[FRM_W-1:1], wr_glob};
        end
    end

    // Replacement pointer: stepped by an advancing pointer read, wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            nlu_ptr <= '0;
        end else if (nlu_step) begin
            nlu_ptr <= (nlu_ptr == IDX_W'(ENTRIES - 1)) ? '0 : nlu_ptr + 1'b1;
        end
    end

    // Read-back register: one cycle after the request, zeros out of range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_tag  <= '0;
            rd_mask <= '0;
            rd_even <= '0;
            rd_odd  <= '0;
        end else if (rd_en) begin
            if (rd_in_range) begin
                rd_tag  <= tag_q[rd_addr[IDX_W-1:0]];
                rd_mask <= mask_q[rd_addr[IDX_W-1:0]];
                rd_even <= even_q[rd_addr[IDX_W-1:0]];
                rd_odd  <= odd_q[rd_addr[IDX_W-1:0]];
            end else begin
                rd_tag  <= '0;
                rd_mask <= '0;
                rd_even <= '0;
                rd_odd  <= '0;
            end
        end
    end

    // Occupancy: a slot is live when either half is valid.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_occ
            assign occ[g] = even_q[g][FB_VALID] | odd_q[g][FB_VALID];
        end
    endgenerate

    // R9: a flush leaves no live slot and a zero pointer.
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (occ == '0 && nlu_ptr == '0));

    // R7: an out-of-range write leaves the occupancy untouched.
    p_oob_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(flush) && (int'($past(wr_idx)) >= ENTRIES))
        |-> occ == $past(occ));

    // R10: an advancing pointer read steps the pointer with wrap.
    p_nlu_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nlu_step) && !$past(flush))
        |-> nlu_ptr == (($past(nlu_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(nlu_ptr) + 1'b1));
endmodule

// File: rtl/tlb_match.sv
// Combinational associative compare, lowest-index priority pick, and
// even/odd half selection. Assumes each mask is contiguous from bit 0.
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = VPN_W + ASID_W,
    localparam int FRM_W  = PFN_W + tlb_pkg::META_W
) (
    input  logic [VPN_W-1:0]                 lk_vpn,
    input  logic                             lk_half,
    input  logic [ASID_W-1:0]                lk_asid,
    input  logic [ENTRIES-1:0][TAG_W-1:0]    tag_q,
    input  logic [ENTRIES-1:0][VPN_W-1:0]    mask_q,
    input  logic [ENTRIES-1:0][FRM_W-1:0]    even_q,
    input  logic [ENTRIES-1:0][FRM_W-1:0]    odd_q,
    input  logic [ENTRIES-1:0]               occ,
    output logic                             hit,
    output logic [IDX_W-1:0]                 win_idx,
    output logic [ENTRIES-1:0]               grant,
    output logic [PFN_W-1:0]                 pfn,
    output tlb_pkg::cattr_t                  cattr,
    output logic                             dirty,
    output logic                             half_valid
);
    import tlb_pkg::*;

    logic [ENTRIES-1:0]            match_vec;
    logic [ENTRIES-1:0][FRM_W-1:0] sel_frame;
    logic [FRM_W-1:0]              win_frame;

    // Per-slot compare and half choice, one copy per slot.
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            logic [VPN_W:0] ext;
            logic           tag_ok;
            logic           id_ok;
            logic           odd_sel;

            // Masked tag compare, identifier check and half-select bit.
            always_comb begin
                ext     = {lk_vpn, lk_half};
                tag_ok  = (((lk_vpn ^ tag_q[e][TAG_W-1:ASID_W]) & ~mask_q[e]) == '0);
                id_ok   = even_q[e][FB_GLOBAL] | (lk_asid == tag_q[e][ASID_W-1:0]);
                odd_sel = ext[0];
                for (int b = 0; b < VPN_W; b++) begin
                    if (mask_q[e][b]) odd_sel = ext[b+1];
                end
            end

            assign match_vec[e] = occ[e] & tag_ok & id_ok;
            assign sel_frame[e] = odd_sel ? odd_q[e] : even_q[e];
        end
    endgenerate

    // Lowest-index winner: one-hot grant and its encoded index.
    always_comb begin
        grant   = match_vec & (~match_vec + 1'b1);
        hit     = |match_vec;
        win_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) win_idx = IDX_W'(e);
        end
    end

    // Fields of the selected half of the winner, zero on a miss.
    always_comb begin
        win_frame  = hit ? sel_frame[win_idx] : '0;
        pfn        = win_frame[FRM_W-1:META_W];
        cattr      = win_frame[FB_CA_LO +: CA_W];
        dirty      = win_frame[FB_DIRTY];
        half_valid = win_frame[FB_VALID];
    end
endmodule

// File: rtl/tlb_paired_xlate.sv
// Top of the paired-page translation buffer. Splits the lookup address,
// instantiates storage and compare, and registers the lookup result.
// Assumes VA_W > PAGE_SHIFT+1 and that UC_PATTERN selects the uncached window.
module tlb_paired_xlate #(
    parameter int               ENTRIES    = 8,
    parameter int               VA_W       = 32,
    parameter int               PAGE_SHIFT = 12,
    parameter int               ASID_W     = 8,
    parameter int               PFN_W      = 20,
    parameter logic [VA_W-1:0]  UC_PATTERN = 32'hA000_0000,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PIDX_W = IDX_W + 1,
    localparam int VPN_W  = VA_W - PAGE_SHIFT - 1,
    localparam int TAG_W  = VPN_W + ASID_W,
    localparam int FRM_W  = PFN_W + tlb_pkg::META_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [VPN_W-1:0]  wr_mask,
    input  logic [FRM_W-1:0]  wr_even,
    input  logic [FRM_W-1:0]  wr_odd,
    input  logic              rd_en,
    input  logic [PIDX_W-1:0] rd_idx,
    input  logic              rd_use_nlu,
    input  logic              rd_advance,
    input  logic              flush,
    output logic              res_hit,
    output logic [PIDX_W-1:0] res_probe,
    output logic [PFN_W-1:0]  res_pfn,
    output logic [2:0]        res_cattr,
    output logic              res_dirty,
    output logic              res_inval,
    output logic              res_uncached,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [VPN_W-1:0]  rd_mask,
    output logic [FRM_W-1:0]  rd_even,
    output logic [FRM_W-1:0]  rd_odd,
    output logic [IDX_W-1:0]  nlu_ptr
);
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][VPN_W-1:0] mask_q;
    logic [ENTRIES-1:0][FRM_W-1:0] even_q;
    logic [ENTRIES-1:0][FRM_W-1:0] odd_q;
    logic [ENTRIES-1:0]            occ;
    logic                          m_hit;
    logic [IDX_W-1:0]              m_idx;
    logic [ENTRIES-1:0]            m_grant;
    logic [PFN_W-1:0]              m_pfn;
    tlb_pkg::cattr_t               m_cattr;
    logic                          m_dirty;
    logic                          m_valid;
    logic                          uc_now;

    tlb_entry_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_mask(wr_mask),
        .wr_even(wr_even), .wr_odd(wr_odd),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_use_nlu(rd_use_nlu), .rd_advance(rd_advance),
        .tag_q(tag_q), .mask_q(mask_q), .even_q(even_q), .odd_q(odd_q), .occ(occ),
        .rd_tag(rd_tag), .rd_mask(rd_mask), .rd_even(rd_even), .rd_odd(rd_odd),
        .nlu_ptr(nlu_ptr)
    );

    tlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
    ) u_match (
        .lk_vpn(lk_vaddr[VA_W-1:PAGE_SHIFT+1]), .lk_half(lk_vaddr[PAGE_SHIFT]),
        .lk_asid(lk_asid),
        .tag_q(tag_q), .mask_q(mask_q), .even_q(even_q), .odd_q(odd_q), .occ(occ),
        .hit(m_hit), .win_idx(m_idx), .grant(m_grant),
        .pfn(m_pfn), .cattr(m_cattr), .dirty(m_dirty), .half_valid(m_valid)
    );

    // Fixed uncached window decode, independent of the table.
    assign uc_now = ((lk_vaddr & UC_PATTERN) == UC_PATTERN);

    // Result register: lookup outcome one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hit      <= 1'b0;
            res_probe    <= '1;
            res_pfn      <= '0;
            res_cattr    <= '0;
            res_dirty    <= 1'b0;
            res_inval    <= 1'b0;
            res_uncached <= 1'b0;
        end else begin
            res_hit      <= m_hit;
            res_probe    <= m_hit ? {1'b0, m_idx} : '1;
            res_pfn      <= m_pfn;
            res_cattr    <= m_cattr;
            res_dirty    <= m_dirty;
            res_inval    <= m_hit & ~m_valid;
            res_uncached <= uc_now;
        end
    end

    // R6: at most one slot is granted, and it is the encoded winner.
    p_single_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_grant) && (!m_hit || m_grant[m_idx]));

    // R4: an invalid-half report only comes with a hit.
    p_inval_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_inval |-> res_hit);

    // R5: a miss always reports the all-ones probe value.
    p_miss_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_probe == '1));

    // R3: a granted slot is always a live slot.
    p_grant_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_grant & ~occ) == '0);
endmodule

// File: tb/tlb_paired_xlate_bench.sv
`timescale 1ns/1ps
module tlb_paired_xlate_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [26:0] wr_tag = '0;
    logic [18:0] wr_mask = '0;
    logic [25:0] wr_even = '0;
    logic [25:0] wr_odd = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic        rd_use_nlu = 1'b0;
    logic        rd_advance = 1'b0;
    logic        flush = 1'b0;
    logic        res_hit;
    logic [3:0]  res_probe;
    logic [19:0] res_pfn;
    logic [2:0]  res_cattr;
    logic        res_dirty, res_inval, res_uncached;
    logic [26:0] rd_tag;
    logic [18:0] rd_mask;
    logic [25:0] rd_even, rd_odd;
    logic [2:0]  nlu_ptr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [26:0] m_tag  [N];
    logic [18:0] m_mask [N];
    logic [25:0] m_even [N];
    logic [25:0] m_odd  [N];

    tlb_paired_xlate u_tlb_paired_xlate (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_mask(wr_mask),
        .wr_even(wr_even), .wr_odd(wr_odd), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_use_nlu(rd_use_nlu), .rd_advance(rd_advance), .flush(flush),
        .res_hit(res_hit), .res_probe(res_probe), .res_pfn(res_pfn),
        .res_cattr(res_cattr), .res_dirty(res_dirty), .res_inval(res_inval),
        .res_uncached(res_uncached), .rd_tag(rd_tag), .rd_mask(rd_mask),
        .rd_even(rd_even), .rd_odd(rd_odd), .nlu_ptr(nlu_ptr)
    );

    always #10 clk = ~clk;

    function automatic logic [25:0] frm(logic [19:0] pfn, logic [2:0] ca,
                                        logic d, logic v, logic g);
        return {pfn, ca, d, v, g};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected {hit, probe, pfn, cattr, dirty, inval, uncached} from the requirements.
    function automatic logic [30:0] model(logic [31:0] va, logic [7:0] asid);
        logic [19:0] ext;
        logic [18:0] vpn;
        logic [25:0] fr;
        logic        uc;
        int          win;
        ext = va[31:12];
        vpn = va[31:13];
        uc  = va[31] & va[29];
        win = -1;
        for (int e = 0; e < N; e++) begin
            if (win < 0 && (m_even[e][1] | m_odd[e][1]) &&
                (((vpn ^ m_tag[e][26:8]) & ~m_mask[e]) == '0) &&
                (m_even[e][0] || asid == m_tag[e][7:0]))
                win = e;
        end
        if (win < 0) return {1'b0, 4'hF, 20'h0, 3'h0, 1'b0, 1'b0, uc};
        fr = ext[$countones(m_mask[win])] ? m_odd[win] : m_even[win];
        return {1'b1, 4'(win), fr[25:6], fr[5:3], fr[2], ~fr[1], uc};
    endfunction

    task automatic write_slot(int idx, logic [18:0] vpn, logic [7:0] asid,
                              logic [18:0] mask, logic [25:0] ev, logic [25:0] od);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_tag = {vpn, asid};
        wr_mask = mask; wr_even = ev; wr_odd = od;
        @(negedge clk);
        wr_en = 1'b0;
        if (idx < N) begin
            m_tag[idx]  = {vpn, asid};
            m_mask[idx] = mask;
            m_even[idx] = {ev[25:1], ev[0] & od[0]};
            m_odd[idx]  = {od[25:1], ev[0] & od[0]};
        end
    endtask

    task automatic look(logic [31:0] va, logic [7:0] asid, string req);
        logic [30:0] exp;
        logic [30:0] act;
        @(negedge clk);
        lk_vaddr = va; lk_asid = asid;
        exp = model(va, asid);
        @(negedge clk);
        act = {res_hit, res_probe, res_pfn, res_cattr, res_dirty, res_inval, res_uncached};
        chk(act == exp, req, $sformatf("lookup va=%h asid=%h", va, asid), 64'(act), 64'(exp));
    endtask

    task automatic read_check(int idx, bit use_nlu, bit adv, string req);
        int a;
        logic [104:0] exp;
        logic [104:0] act;
        @(negedge clk);
        a = use_nlu ? int'(nlu_ptr) : idx;
        rd_en = 1'b1; rd_idx = 4'(idx); rd_use_nlu = use_nlu; rd_advance = adv;
        @(negedge clk);
        rd_en = 1'b0; rd_use_nlu = 1'b0; rd_advance = 1'b0;
        exp = (a < N) ? {m_tag[a], m_mask[a], m_even[a], m_odd[a]} : '0;
        act = {rd_tag, rd_mask, rd_even, rd_odd};
        chk(act == exp, req, $sformatf("read slot %0d", a), act[63:0], exp[63:0]);
    endtask

    task automatic sweep(string req);
        logic [18:0] bases [4];
        logic [7:0]  ids [4];
        bases[0] = 19'h00010; bases[1] = 19'h00100; bases[2] = 19'h00200; bases[3] = 19'h50000;
        ids[0] = 8'h05; ids[1] = 8'h06; ids[2] = 8'h07; ids[3] = 8'h09;
        for (int b = 0; b < 4; b++)
            for (int o = 0; o < 16; o++)
                for (int a = 0; a < 4; a++)
                    for (int h = 0; h < 2; h++)
                        look({bases[b] + 19'(o), 1'(h), 12'h5A3}, ids[a], req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_mask[i] = '0; m_even[i] = '0; m_odd[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state.
        chk(res_hit == 1'b0, "R12", "hit after reset", 64'(res_hit), 64'(0));
        chk(res_probe == 4'hF, "R12", "probe after reset", 64'(res_probe), 64'hF);
        chk(nlu_ptr == 3'd0, "R12", "pointer after reset", 64'(nlu_ptr), 64'(0));

        // Table population.
        write_slot(0, 19'h00010, 8'h05, 19'h0, frm(20'h00111, 3'd3, 1, 1, 0), frm(20'h00222, 3'd2, 0, 1, 0));
        write_slot(1, 19'h00100, 8'h07, 19'h3, frm(20'h00333, 3'd5, 0, 1, 1), frm(20'h00344, 3'd1, 1, 0, 1));
        write_slot(2, 19'h00010, 8'h06, 19'h0, frm(20'h00555, 3'd0, 0, 1, 0), frm(20'h00566, 3'd7, 1, 1, 0));
        write_slot(3, 19'h00010, 8'h05, 19'h0, frm(20'h00777, 3'd1, 1, 1, 0), frm(20'h00788, 3'd1, 1, 1, 0));
        write_slot(4, 19'h00200, 8'h05, 19'h0, frm(20'h00AAA, 3'd2, 1, 0, 1), frm(20'h00ABB, 3'd2, 1, 0, 1));
        write_slot(5, 19'h50000, 8'h09, 19'hF, frm(20'h00888, 3'd4, 1, 1, 1), frm(20'h00899, 3'd6, 0, 1, 1));
        write_slot(6, 19'h00204, 8'h05, 19'h1, frm(20'h009A0, 3'd3, 0, 0, 0), frm(20'h009AB, 3'd3, 1, 1, 0));

        // R8: read back every slot plus one index past the table.
        for (int i = 0; i < N; i++) read_check(i, 0, 0, "R8");
        read_check(9, 0, 0, "R8");

        // R12: result changes only at the clock edge after the address.
        @(negedge clk);
        lk_vaddr = {19'h00010, 1'b0, 12'h0}; lk_asid = 8'h06;
        @(negedge clk);
        lk_vaddr = {19'h00010, 1'b1, 12'h0}; lk_asid = 8'h05;
        #1;
        chk(res_probe == 4'd2, "R12", "previous result held before edge", 64'(res_probe), 64'd2);
        @(negedge clk);
        chk(res_probe == 4'd0 && res_pfn == 20'h00222, "R12", "new result after edge",
            64'({res_probe, res_pfn}), 64'({4'd0, 20'h00222}));

        // Targeted cases.
        look({19'h00010, 1'b0, 12'h0}, 8'h05, "R6 lowest index wins");
        chk(res_probe == 4'd0, "R6", "priority winner", 64'(res_probe), 64'd0);
        look({19'h00102, 1'b1, 12'h0}, 8'h33, "R2 R4 global odd half");
        chk(res_hit && res_inval && res_pfn == 20'h00344, "R4", "invalid odd half",
            64'({res_hit, res_inval, res_pfn}), 64'({1'b1, 1'b1, 20'h00344}));
        look({19'h00200, 1'b0, 12'h0}, 8'h05, "R3 unoccupied slot");
        chk(!res_hit && res_probe == 4'hF, "R3 R5", "unoccupied slot misses",
            64'({res_hit, res_probe}), 64'({1'b0, 4'hF}));
        look({19'h50007, 1'b1, 12'h0}, 8'h00, "R11 uncached hit");
        chk(res_hit && res_uncached && res_pfn == 20'h00888, "R11", "uncached with hit",
            64'({res_hit, res_uncached, res_pfn}), 64'({1'b1, 1'b1, 20'h00888}));

        // R1 R2 R3 R4 R5 R6 R11: cross sweep.
        sweep("R1 R2 R3 R4 R5 R6 R11 sweep");

        // R7: out-of-range write dropped, in-range write replaces whole slot.
        write_slot(9, 19'h00300, 8'h05, 19'h0, frm(20'h0F00D, 3'd1, 1, 1, 1), frm(20'h0F00E, 3'd1, 1, 1, 1));
        look({19'h00300, 1'b0, 12'h0}, 8'h05, "R7 out-of-range write dropped");
        chk(!res_hit, "R7", "dropped write not visible", 64'(res_hit), 64'd0);
        for (int i = 0; i < N; i++) read_check(i, 0, 0, "R7 table unchanged");
        write_slot(2, 19'h00108, 8'h06, 19'h0, frm(20'h0ABCD, 3'd6, 1, 1, 0), frm(20'h0ABCE, 3'd6, 0, 0, 0));
        look({19'h00108, 1'b0, 12'h0}, 8'h06, "R7 rewritten slot hits");
        chk(res_hit && res_probe == 4'd2, "R7", "new contents", 64'({res_hit, res_probe}), 64'({1'b1, 4'd2}));
        sweep("R1 R7 sweep after rewrite");

        // R10: pointer reads with and without advance, through the wrap.
        read_check(0, 1, 0, "R10 pointer read no step");
        chk(nlu_ptr == 3'd0, "R10", "pointer held", 64'(nlu_ptr), 64'd0);
        for (int k = 0; k < N + 2; k++) begin
            read_check(0, 1, 1, "R10 pointer read");
            chk(nlu_ptr == 3'((k + 1) % N), "R10", "pointer step", 64'(nlu_ptr), 64'((k + 1) % N));
        end
        read_check(5, 0, 1, "R10 indexed read");
        chk(nlu_ptr == 3'd2, "R10", "indexed read keeps pointer", 64'(nlu_ptr), 64'd2);

        // R11: uncached window across the top address nibble, no hits.
        for (int t = 0; t < 16; t++) begin
            look({4'(t), 28'h0001234}, 8'h44, "R11 window decode");
            chk(res_uncached == (t[3] & t[1]), "R11", $sformatf("nibble %0d", t),
                64'(res_uncached), 64'(t[3] & t[1]));
        end

        // R9: flush with a simultaneous write.
        @(negedge clk);
        flush = 1'b1; wr_en = 1'b1; wr_idx = 4'd0; wr_tag = {19'h00010, 8'h05};
        wr_even = frm(20'h1, 3'd0, 0, 1, 0); wr_odd = frm(20'h2, 3'd0, 0, 1, 0); wr_mask = '0;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_mask[i] = '0; m_even[i] = '0; m_odd[i] = '0;
        end
        chk(nlu_ptr == 3'd0, "R9", "pointer after flush", 64'(nlu_ptr), 64'd0);
        for (int i = 0; i < N; i++) read_check(i, 0, 0, "R9 slot cleared");
        look({19'h00010, 1'b0, 12'h0}, 8'h05, "R9 miss after flush");
        chk(!res_hit, "R9", "write lost to flush", 64'(res_hit), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule